// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block is the digital sequencer for one phase of an H-bridge current regulator. It drives the four gate enables of the bridge, a high-side and a low-side switch on each of legs A and B. In the drive phase the diagonal pair made of the A high-side and the B low-side conducts. The phase ends when the current-sense comparator trips outside a blanking window. A fixed off-time then follows. During the off-time the winding current decays slowly, quickly, or first quickly and then slowly, and the switches opposite the body diodes can be used for synchronous rectification.

Three input buses give the off-time, the blanking window and the fast part of a mixed decay as clock-cycle counts. A step pulse from the translator above the block restarts the drive phase and the blanking window. A disable input forces all gates off but leaves the timing running. A per-leg dead-time stage sits between the sequencer and the gates. It never lets both switches of one leg conduct at once, and it keeps a leg idle for a few clocks before either of its switches turns on.

Top module: `pwm_chopper`

## Requirements
- R1: In the cycle after a reset edge all four gates are off. Once the dead-time window has passed, the block drives A high-side and B low-side (gate order a_hi, a_lo, b_hi, b_lo) and holds them while no trip is accepted.
- R2: After each entry into the drive phase, a trip input is ignored for blank_cycles_i clock cycles. A trip present in the following cycle is accepted. Reset itself is not an entry, so a trip is accepted at once after reset.
- R3: An accepted trip starts an off-time that lasts exactly off_cycles_i cycles, with 0 treated as 1. After the off-time the drive phase resumes with the blanking window reloaded.
- R4: Decay select 0 (slow, and also the unused code 3): in the off-time A high-side is off and B low-side stays on. A low-side is on only while synchronous rectification is allowed.
- R5: Decay select 1 (fast): A high-side and B low-side are both off for the whole off-time. B high-side and A low-side are on only while synchronous rectification is allowed.
- R6: Decay select 2 (mixed): the first min(fast_cycles_i, off-time) cycles of the off-time behave as R5 and the rest behave as R4. A fast count larger than the off-time is clamped to it.
- R7: While sr_off_i is high no synchronous switch is enabled. B high-side is never on, and in the off-time A low-side is off.
- R8: With synchronous rectification on, a zero_cur_i pulse during an off-time releases the synchronous switches at once and keeps them released until that off-time ends.
- R9: While out_dis_i is high all gates are off in the next cycle. Trip, blanking and off-time timing carry on unchanged.
- R10: The two gates of one leg are never on together. A gate turns on only after its leg has been fully off for at least DEAD cycles.
- R11: A step_i pulse puts the block in the drive phase in the next cycle with blanking reloaded, even in the middle of an off-time.
- R12: The decay select, the off-time and the fast count are latched at the accepted trip. Changes made during an off-time take effect from the next trip on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Current-sense comparator output, high at trip |
| decay_sel_i | input | 2 | 0 slow, 1 fast, 2 mixed, 3 slow |
| out_dis_i | input | 1 | High forces all gates off |
| sr_off_i | input | 1 | High disables synchronous rectification |
| zero_cur_i | input | 1 | Zero-current detect, high when winding current is near zero |
| step_i | input | 1 | New-step pulse, restarts the drive phase |
| off_cycles_i | input | CNT_W | Off-time in clock cycles |
| blank_cycles_i | input | CNT_W | Blanking window in clock cycles |
| fast_cycles_i | input | CNT_W | Fast-decay part of a mixed off-time in cycles |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |

## Verification
The chopper is driven with a trip held through the blanking window, single trip pulses in each decay select, and a trip held high for repeated chop cycles. Each of these patterns separates a different property:
- Blanking is told apart from an early off-time by the trip held through the window.
- Slow and fast decay are told apart by whether B low-side stays on during the off-time.
- Mixed decay is told apart by the cycle at which it switches from fast to slow.
- Clamping is exercised with a fast count larger than the off-time.

Separate runs cover zero-current pulses, rectification turned off, the disable input, off-time values of 0 and 1, and a step pulse or a decay-select change in the middle of an off-time. These runs expose wrong latching, a wrong restart and wrong masking. The gate pattern is compared every cycle with a behavioural model that includes dead-time.

// File: rtl/chop_pkg.sv
// Shared types for the PWM current chopper.
// Assumes: a two-bit decay select and one bridge per instance.
package chop_pkg;

    typedef enum logic [1:0] {
        DEC_SLOW  = 2'd0,
        DEC_FAST  = 2'd1,
        DEC_MIXED = 2'd2,
        DEC_RSVD  = 2'd3
    } decay_e;

    typedef enum logic {
        PH_DRIVE = 1'b0,
        PH_DECAY = 1'b1
    } phase_e;

    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic b_hi;
        logic b_lo;
    } gate_req_t;

endpackage

// File: rtl/chop_timer.sv
// Phase sequencer. It runs the blanking window after drive entry, the fixed
// off-time after an accepted trip, and the fast/slow split inside the off-time.
// It also latches the zero-current flag for the off-time.
// Assumes: inputs synchronous to clk; step_i wins over every other event.
module chop_timer
    import chop_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_i,
    input  logic             step_i,
    input  logic [1:0]       decay_sel_i,
    input  logic             zero_cur_i,
    input  logic [CNT_W-1:0] off_cycles_i,
    input  logic [CNT_W-1:0] blank_cycles_i,
    input  logic [CNT_W-1:0] fast_cycles_i,
    output phase_e           phase_o,
    output logic             fast_o,
    output logic             zc_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           phase_q;
    logic [CNT_W-1:0] blank_q;
    logic [CNT_W-1:0] el_q;
    logic [CNT_W-1:0] off_lat_q;
    logic [CNT_W-1:0] fast_lat_q;
    logic             zc_q;
    logic [CNT_W-1:0] off_eff;
    logic [CNT_W-1:0] fast_eff;
    logic             off_done;

    // Off-time length with a zero request raised to one cycle.
    always_comb off_eff = (off_cycles_i == '0) ? ONE : off_cycles_i;

    // Fast-decay share of the off-time for the selected mode, clamped.
    always_comb begin
        case (decay_e'(decay_sel_i))
            DEC_FAST:  fast_eff = off_eff;
            DEC_MIXED: fast_eff = (fast_cycles_i > off_eff) ? off_eff : fast_cycles_i;
            default:   fast_eff = '0;
        endcase
    end

    // Last cycle of the off-time reached.
    always_comb off_done = ({1'b0, el_q} + {1'b0, ONE}) >= {1'b0, off_lat_q};

    // Phase, blanking, elapsed-time and zero-current state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_DRIVE;
            blank_q    <= '0;
            el_q       <= '0;
            off_lat_q  <= ONE;
            fast_lat_q <= '0;
            zc_q       <= 1'b0;
        end else if (step_i) begin
            phase_q <= PH_DRIVE;
            blank_q <= blank_cycles_i;
            zc_q    <= 1'b0;
        end else if (phase_q == PH_DRIVE) begin
            if (blank_q != '0) begin
                blank_q <= blank_q - ONE;
            end else if (trip_i) begin
                phase_q    <= PH_DECAY;
                el_q       <= '0;
                off_lat_q  <= off_eff;
                fast_lat_q <= fast_eff;
                zc_q       <= 1'b0;
            end
        end else begin
            if (zero_cur_i) zc_q <= 1'b1;
            if (off_done) begin
                phase_q <= PH_DRIVE;
                blank_q <= blank_cycles_i;
            end else begin
                el_q <= el_q + ONE;
            end
        end
    end

    assign phase_o = phase_q;
    assign fast_o  = (phase_q == PH_DECAY) && (el_q < fast_lat_q);
    assign zc_o    = zc_q;

    // Fast share never longer than the latched off-time.
    p_fast_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fast_lat_q <= off_lat_q);

    // Elapsed count stays inside the latched off-time window.
    p_off_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DECAY) |-> (el_q < off_lat_q));

    // No off-time starts while blanking is still counting.
    p_blank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DRIVE && blank_q != '0) |=> (phase_q == PH_DRIVE));

    // A step pulse always leads to the drive phase.
    p_step_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (phase_q == PH_DRIVE));

endmodule

// File: rtl/chop_gate_map.sv
// Combinational map from sequencer state to requested gate pattern.
// Handles decay style, synchronous rectification, zero-current release and
// the output disable. Assumes: leg A high / leg B low is the drive diagonal.
module chop_gate_map
    import chop_pkg::*;
(
    input  phase_e    phase_i,
    input  logic      fast_i,
    input  logic      zc_lat_i,
    input  logic      zero_cur_i,
    input  logic      sr_off_i,
    input  logic      out_dis_i,
    output gate_req_t req_o
);

    logic sync_ok;

    // Synchronous switches allowed only with SR on and no zero current seen.
    always_comb sync_ok = !sr_off_i && !(zc_lat_i || zero_cur_i);

    // Pattern selection per phase and decay style.
    always_comb begin
        req_o = '0;
        if (!out_dis_i) begin
            if (phase_i == PH_DRIVE) begin
                req_o.a_hi = 1'b1;
                req_o.b_lo = 1'b1;
            end else if (fast_i) begin
                req_o.a_lo = sync_ok;
                req_o.b_hi = sync_ok;
            end else begin
                req_o.b_lo = 1'b1;
                req_o.a_lo = sync_ok;
            end
        end
    end

endmodule

// File: rtl/chop_leg_deadtime.sv
// Dead-time stage for one bridge leg. Turn-off is immediate. A turn-on waits
// until the leg has been fully off for DEAD+1 cycles. The low side yields if
// both sides are requested together. Assumes: requests are synchronous to clk.
module chop_leg_deadtime #(
    parameter int DEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_req_i,
    input  logic lo_req_i,
    output logic hi_o,
    output logic lo_o
);

    localparam int             DT_W    = (DEAD < 1) ? 1 : $clog2(DEAD + 1);
    localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD);

    logic [DT_W-1:0] cnt_q;
    logic            hi_q;
    logic            lo_q;
    logic            idle_ok;

    // Leg idle long enough for a new switch to turn on.
    always_comb idle_ok = !hi_q && !lo_q && (cnt_q == '0);

    // Gate registers and dead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
            cnt_q <= DT_LOAD;
        end else begin
            hi_q <= hi_req_i && (hi_q || idle_ok);
            lo_q <= lo_req_i && (lo_q || (idle_ok && !hi_req_i));
            if (hi_q || lo_q)      cnt_q <= DT_LOAD;
            else if (cnt_q != '0)  cnt_q <= cnt_q - DT_W'(1);
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // Never both switches of the leg on.
    p_no_shoot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q));

    // A turning-on high side follows a cycle with the low side off.
    p_hi_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> !$past(lo_q));

    // A turning-on low side follows a cycle with the high side off.
    p_lo_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_q) |-> !$past(hi_q));

endmodule

// File: rtl/pwm_chopper.sv
// Top of the fixed off-time PWM chopper for one H-bridge phase. It joins the
// sequencer, the gate map and one dead-time stage per leg.
// Assumes: trip and zero-current inputs are already synchronised to clk.
module pwm_chopper
    import chop_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DEAD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_i,
    input  logic [1:0]       decay_sel_i,
    input  logic             out_dis_i,
    input  logic             sr_off_i,
    input  logic             zero_cur_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] off_cycles_i,
    input  logic [CNT_W-1:0] blank_cycles_i,
    input  logic [CNT_W-1:0] fast_cycles_i,
    output logic             a_hi_o,
    output logic             a_lo_o,
    output logic             b_hi_o,
    output logic             b_lo_o
);

    localparam int LEGS = 2;

    phase_e          phase;
    logic            fast;
    logic            zc_lat;
    gate_req_t       req;
    logic [LEGS-1:0] hi_req;
    logic [LEGS-1:0] lo_req;
    logic [LEGS-1:0] hi_g;
    logic [LEGS-1:0] lo_g;

    chop_timer #(.CNT_W(CNT_W)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .trip_i         (trip_i),
        .step_i         (step_i),
        .decay_sel_i    (decay_sel_i),
        .zero_cur_i     (zero_cur_i),
        .off_cycles_i   (off_cycles_i),
        .blank_cycles_i (blank_cycles_i),
        .fast_cycles_i  (fast_cycles_i),
        .phase_o        (phase),
        .fast_o         (fast),
        .zc_o           (zc_lat)
    );

    chop_gate_map u_map (
        .phase_i    (phase),
        .fast_i     (fast),
        .zc_lat_i   (zc_lat),
        .zero_cur_i (zero_cur_i),
        .sr_off_i   (sr_off_i),
        .out_dis_i  (out_dis_i),
        .req_o      (req)
    );

    // Leg 0 is A, leg 1 is B.
    assign hi_req = {req.b_hi, req.a_hi};
    assign lo_req = {req.b_lo, req.a_lo};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        chop_leg_deadtime #(.DEAD(DEAD)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_req_i (hi_req[g]),
            .lo_req_i (lo_req[g]),
            .hi_o     (hi_g[g]),
            .lo_o     (lo_g[g])
        );
    end

    assign a_hi_o = hi_g[0];
    assign a_lo_o = lo_g[0];
    assign b_hi_o = hi_g[1];
    assign b_lo_o = lo_g[1];

    // Disable forces every gate off one cycle later.
    p_disable_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis_i |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

    // B high-side is only ever a synchronous switch.
    p_no_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_off_i |=> !b_hi_o);

    // At most one switch per leg, seen at the ports.
    p_leg_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi_o && a_lo_o) && !(b_hi_o && b_lo_o));

endmodule

// File: tb/tb_pwm_chopper.sv
module tb_pwm_chopper;

    localparam int CNT_W = 8;
    localparam int DEAD  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trip = 1'b0;
    logic [1:0]       dsel = 2'd0;
    logic             odis = 1'b0;
    logic             sroff = 1'b0;
    logic             zcur = 1'b0;
    logic             step = 1'b0;
    logic [CNT_W-1:0] offc = 8'd12;
    logic [CNT_W-1:0] blkc = 8'd4;
    logic [CNT_W-1:0] fstc = 8'd5;
    logic             a_hi, a_lo, b_hi, b_lo;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string tag = "R1";

    pwm_chopper #(.CNT_W(CNT_W), .DEAD(DEAD)) dut (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .decay_sel_i(dsel),
        .out_dis_i(odis), .sr_off_i(sroff), .zero_cur_i(zcur), .step_i(step),
        .off_cycles_i(offc), .blank_cycles_i(blkc), .fast_cycles_i(fstc),
        .a_hi_o(a_hi), .a_lo_o(a_lo), .b_hi_o(b_hi), .b_lo_o(b_lo)
    );

    always #5 clk = ~clk;

    // Behavioural reference model, updated at each rising edge.
    int m_decay, m_blank, m_el, m_off, m_fast, m_zc;
    bit [3:0] m_g;
    int run_a, run_b;

    always @(posedge clk) begin
        bit sync;
        bit [3:0] rq;
        bit [3:0] ng;
        int offe, faste;
        bit offa, offb;
        if (!rst_n) begin
            m_decay = 0; m_blank = 0; m_el = 0; m_off = 1; m_fast = 0; m_zc = 0;
            m_g = 4'b0; run_a = 0; run_b = 0;
        end else begin
            sync = !sroff && !(m_zc != 0 || zcur);
            rq = 4'b0;  // {a_hi, a_lo, b_hi, b_lo}
            if (!odis) begin
                if (m_decay == 0)        rq = 4'b1001;
                else if (m_el < m_fast)  rq = {1'b0, sync, sync, 1'b0};
                else                     rq = {1'b0, sync, 1'b0, 1'b1};
            end
            offa = !m_g[3] && !m_g[2];
            offb = !m_g[1] && !m_g[0];
            run_a = offa ? run_a + 1 : 0;
            run_b = offb ? run_b + 1 : 0;
            ng[3] = rq[3] && (m_g[3] || (offa && run_a >= DEAD + 1));
            ng[2] = rq[2] && (m_g[2] || (offa && run_a >= DEAD + 1 && !rq[3]));
            ng[1] = rq[1] && (m_g[1] || (offb && run_b >= DEAD + 1));
            ng[0] = rq[0] && (m_g[0] || (offb && run_b >= DEAD + 1 && !rq[1]));
            m_g = ng;
            offe = (offc == 0) ? 1 : int'(offc);
            faste = (dsel == 2'd1) ? offe :
                    (dsel == 2'd2) ? ((int'(fstc) > offe) ? offe : int'(fstc)) : 0;
            if (step) begin
                m_decay = 0; m_blank = int'(blkc); m_zc = 0;
            end else if (m_decay == 0) begin
                if (m_blank != 0) m_blank = m_blank - 1;
                else if (trip) begin
                    m_decay = 1; m_el = 0; m_off = offe; m_fast = faste; m_zc = 0;
                end
            end else begin
                if (zcur) m_zc = 1;
                if (m_el + 1 >= m_off) begin
                    m_decay = 0; m_blank = int'(blkc);
                end else m_el = m_el + 1;
            end
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if ({a_hi, a_lo, b_hi, b_lo} !== m_g) begin
                miscompares++;
                $display("FAIL %s: gates a_hi,a_lo,b_hi,b_lo actual %b expected %b",
                         tag, {a_hi, a_lo, b_hi, b_lo}, m_g);
            end
            vectors++;
            if ((a_hi && a_lo) || (b_hi && b_lo)) begin
                miscompares++;
                $display("FAIL R10: leg overlap actual %b expected no leg with both on",
                         {a_hi, a_lo, b_hi, b_lo});
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic trip_pulse();
        trip = 1'b1; cyc(1); trip = 1'b0;
    endtask

    initial begin
        cyc(3);
        vectors++;
        if ({a_hi, a_lo, b_hi, b_lo} !== 4'b0) begin
            miscompares++;
            $display("FAIL R1: reset gates actual %b expected 0000", {a_hi, a_lo, b_hi, b_lo});
        end
        rst_n = 1'b1;
        tag = "R1"; cyc(15);
        tag = "R2"; step = 1'b1; cyc(1); step = 1'b0;
        trip = 1'b1; cyc(3); trip = 1'b0; cyc(10);
        tag = "R4"; dsel = 2'd0; trip_pulse(); cyc(25);
        tag = "R5"; dsel = 2'd1; trip_pulse(); cyc(25);
        tag = "R6"; dsel = 2'd2; trip_pulse(); cyc(25);
        tag = "R6"; fstc = 8'd40; trip_pulse(); cyc(25); fstc = 8'd5;
        tag = "R7"; sroff = 1'b1; dsel = 2'd1; trip_pulse(); cyc(25);
        dsel = 2'd0; trip_pulse(); cyc(25); sroff = 1'b0;
        tag = "R8"; dsel = 2'd0; trip_pulse(); cyc(4);
        zcur = 1'b1; cyc(1); zcur = 1'b0; cyc(20);
        dsel = 2'd1; trip_pulse(); cyc(3); zcur = 1'b1; cyc(1); zcur = 1'b0; cyc(20);
        tag = "R9"; odis = 1'b1; trip = 1'b1; cyc(30); trip = 1'b0; odis = 1'b0; cyc(10);
        tag = "R11"; dsel = 2'd1; trip_pulse(); cyc(5);
        step = 1'b1; cyc(1); step = 1'b0; cyc(15);
        tag = "R12"; dsel = 2'd2; trip_pulse(); cyc(2);
        dsel = 2'd0; offc = 8'd3; fstc = 8'd1; cyc(20);
        trip_pulse(); cyc(15); offc = 8'd12; fstc = 8'd5;
        tag = "R3"; offc = 8'd0; trip_pulse(); cyc(10);
        offc = 8'd1; trip_pulse(); cyc(10); offc = 8'd12;
        blkc = 8'd0; dsel = 2'd2; trip = 1'b1; cyc(60); trip = 1'b0; cyc(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #1500000;
        done = 1'b1;
        miscompares++;
        $display("FAIL %s: watchdog actual timeout expected completion", tag);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule